// File: doc/BRIEF.md
# Delayed-Read Target Controller

This block sits behind the address decoder of a 32-bit PCI target and turns target reads into delayed transactions toward a simple local memory bus. When a read arrives with nothing pending, the controller records its address and byte enables, answers the master with Retry, and launches exactly one single-word read on the local bus. The word that comes back is parked in a hold register. When the master comes back with the identical request, the read completes at once from that register.

While an entry is parked, a discard timer runs. If the master has not come back within 2^TMR_W clocks (2^15 by default), the entry is dropped, so that a master that has gone away cannot lock the target. Two configuration bits choose how writes interact with a parked entry: they can be bounced with Retry, or they can go through and throw the entry away. A third bit lets a competing read replace the parked entry instead of being retried.

The request side is a one-cycle strobe carrying command, address and byte enables. It is answered by a one-cycle Retry or Done pulse in the next cycle. The local side is a request/acknowledge handshake.

Top module: `pci_dly_rd_ctrl`

## Requirements
- R1: After the active-low synchronous reset, no entry is pending, no local read is outstanding (`lcl_req`=0), and neither `rsp_retry` nor `rsp_done` is asserted.
- R2: A read that arrives with no entry pending is answered with `rsp_retry` in the next cycle. In that same next cycle, `lcl_req` rises with `lcl_addr` equal to the request address and `lcl_be` equal to the request byte enables, whether the enables are aligned or not.
- R3: Each delayed read produces exactly one local transfer. `lcl_req` stays high with `lcl_addr` and `lcl_be` stable until a cycle in which `lcl_ack` is high. The transfer ends in that cycle and `lcl_rdata` is captured.
- R4: While the local read is still outstanding, any read, including one identical to the pending request, is answered with `rsp_retry` and starts no further local transfer.
- R5: Once the data is held, a read whose address and all four byte enables equal the pending ones is answered with `rsp_done` and `rsp_rdata` equal to the held word. This retires the entry, so a repeat of the same read afterwards starts a new delayed read.
- R6: With `cfg_flush_new`=0 and the timer not expired, a read that differs in address or byte enables is answered with `rsp_retry`. It starts no local transfer and leaves the held entry intact.
- R7: With `cfg_flush_new`=1, a non-matching read that arrives while data is held discards the entry and is itself accepted as a new delayed read (Retry plus one local read of its address). While the local read is outstanding, such a read is still only retried.
- R8: The discard timer counts clocks while data is held and restarts from zero each time data is newly held. After 2^TMR_W such clocks without a matching read, the entry is dropped and the next read is accepted as a fresh delayed read.
- R9: With `cfg_wr_retry`=1, a write that arrives while an entry is pending (local read outstanding or data held) is answered with `rsp_retry`. This takes precedence over `cfg_wr_flush`.
- R10: With `cfg_wr_retry`=0 and `cfg_wr_flush`=1, a write during a pending entry is answered with `rsp_done` and discards the entry. If the local read is still outstanding, its returned word is dropped on arrival.
- R11: A write with no entry pending, or with both write options clear, is answered with `rsp_done` and leaves any pending entry untouched.
- R12: Every request gets exactly one response pulse, one cycle after its strobe. `rsp_retry` and `rsp_done` are never high together, and no response appears without a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flush_new | input | 1 | A competing read replaces the held entry |
| cfg_wr_retry | input | 1 | Retry writes while an entry is pending |
| cfg_wr_flush | input | 1 | Writes discard a pending entry |
| req_valid | input | 1 | One-cycle request strobe |
| req_is_write | input | 1 | 1 = write command, 0 = read command |
| req_addr | input | ADDR_W | Request address |
| req_be | input | DATA_W/8 | Request byte enables, active high |
| rsp_retry | output | 1 | Pulse: master must retry |
| rsp_done | output | 1 | Pulse: request completed |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_done` on reads |
| lcl_req | output | 1 | Local read request, held until acknowledged |
| lcl_addr | output | ADDR_W | Local read address |
| lcl_be | output | DATA_W/8 | Local byte enables, active high |
| lcl_ack | input | 1 | Local acknowledge, ends the transfer |
| lcl_rdata | input | DATA_W | Local read data, valid with `lcl_ack` |

## Verification
The assertions assume that `lcl_ack` is asserted only while `lcl_req` is high, and then for a single cycle. They also assume that request strobes last one cycle and that the configuration bits stay steady while a request is being answered. The bench's local-memory model acknowledges only an outstanding request, after a fixed latency, and drops `lcl_ack` in the following cycle. Its driver separates strobes with an idle cycle and changes configuration bits only between scenarios. The discard timer is shortened through TMR_W, so that both sides of the expiry boundary fit in the run.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_WAIT_LCL = 2'd1,
        S_DATA_RDY = 2'd2,
        S_COMPLETE = 2'd3
    } dr_state_e;

endpackage

// File: rtl/pdr_req_match.sv
module pdr_req_match #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [BE_W-1:0]   pend_be,
    output logic              hit
);
    logic [BE_W-1:0] lane_eq;

    // per-lane enable comparison
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_eq[g] = (req_be[g] == pend_be[g]);
    end

    assign hit = (req_addr == pend_addr) && (&lane_eq);

endmodule

// File: rtl/pdr_discard_timer.sv
module pdr_discard_timer #(
    parameter int TMR_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expired = &tmr_q.cnt;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (!expired) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R8: timer idles at zero whenever nothing is held
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);

endmodule

// File: rtl/pdr_local_port.sv
module pdr_local_port #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [BE_W-1:0]   start_be,
    output logic              lcl_req,
    output logic [ADDR_W-1:0] lcl_addr,
    output logic [BE_W-1:0]   lcl_be,
    input  logic              lcl_ack,
    output logic              done
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
    } port_t;

    port_t port_d, port_q;

    assign done     = port_q.req & lcl_ack;
    assign lcl_req  = port_q.req;
    assign lcl_addr = port_q.addr;
    assign lcl_be   = port_q.be;

    always_comb begin
        port_d = port_q;
        if (done) begin
            port_d.req = 1'b0;
        end
        if (start) begin
            port_d.req  = 1'b1;
            port_d.addr = start_addr;
            port_d.be   = start_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    // R3: request and its qualifiers hold until acknowledged
    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_req && !lcl_ack |=> lcl_req && $stable(lcl_addr) && $stable(lcl_be));

    // R3: a new transfer never overlaps an unfinished one
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!lcl_req || lcl_ack));

endmodule

// File: rtl/pci_dly_rd_ctrl.sv
module pci_dly_rd_ctrl
    import pdr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_flush_new,
    input  logic                  cfg_wr_retry,
    input  logic                  cfg_wr_flush,
    input  logic                  req_valid,
    input  logic                  req_is_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rsp_retry,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  lcl_req,
    output logic [ADDR_W-1:0]     lcl_addr,
    output logic [DATA_W/8-1:0]   lcl_be,
    input  logic                  lcl_ack,
    input  logic [DATA_W-1:0]     lcl_rdata
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        dr_state_e         state;
        logic [ADDR_W-1:0] pend_addr;
        logic [BE_W-1:0]   pend_be;
        logic              drop;
        logic [DATA_W-1:0] hold;
        logic              rsp_retry;
        logic              rsp_done;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    dr_state_e eff_state;
    logic      busy;
    logic      take_new;
    logic      hit;
    logic      tmr_expired;
    logic      lcl_start;
    logic      lcl_done;

    pdr_req_match #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_match (
        .req_addr  (req_addr),
        .req_be    (req_be),
        .pend_addr (ctl_q.pend_addr),
        .pend_be   (ctl_q.pend_be),
        .hit       (hit)
    );

    pdr_discard_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.state == S_DATA_RDY),
        .expired (tmr_expired)
    );

    pdr_local_port #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_lport (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (lcl_start),
        .start_addr (req_addr),
        .start_be   (req_be),
        .lcl_req    (lcl_req),
        .lcl_addr   (lcl_addr),
        .lcl_be     (lcl_be),
        .lcl_ack    (lcl_ack),
        .done       (lcl_done)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_retry = 1'b0;
        ctl_d.rsp_done  = 1'b0;
        ctl_d.rsp_data  = '0;
        lcl_start       = 1'b0;
        take_new        = 1'b0;

        if (ctl_q.state == S_COMPLETE) begin
            ctl_d.state = S_IDLE;
        end

        // local data arrival is applied before the request is judged
        if (lcl_done && ctl_q.state == S_WAIT_LCL) begin
            if (ctl_q.drop) begin
                ctl_d.state = S_IDLE;
                ctl_d.drop  = 1'b0;
            end else begin
                ctl_d.state = S_DATA_RDY;
                ctl_d.hold  = lcl_rdata;
            end
        end

        eff_state = ctl_d.state;
        busy      = (eff_state == S_WAIT_LCL) || (eff_state == S_DATA_RDY);

        if (req_valid && req_is_write) begin
            if (busy && cfg_wr_retry) begin
                ctl_d.rsp_retry = 1'b1;
            end else begin
                ctl_d.rsp_done = 1'b1;
                if (busy && cfg_wr_flush) begin
                    if (eff_state == S_DATA_RDY) ctl_d.state = S_IDLE;
                    else                         ctl_d.drop  = 1'b1;
                end
            end
        end else if (req_valid) begin
            unique case (eff_state)
                S_IDLE, S_COMPLETE: take_new = 1'b1;
                S_WAIT_LCL:         ctl_d.rsp_retry = 1'b1;
                S_DATA_RDY: begin
                    if (hit) begin
                        ctl_d.rsp_done = 1'b1;
                        ctl_d.rsp_data = ctl_d.hold;
                        ctl_d.state    = S_COMPLETE;
                    end else if (cfg_flush_new || tmr_expired) begin
                        take_new = 1'b1;
                    end else begin
                        ctl_d.rsp_retry = 1'b1;
                    end
                end
                default: ctl_d.rsp_retry = 1'b1;
            endcase
            if (take_new) begin
                ctl_d.pend_addr = req_addr;
                ctl_d.pend_be   = req_be;
                ctl_d.drop      = 1'b0;
                ctl_d.state     = S_WAIT_LCL;
                ctl_d.rsp_retry = 1'b1;
                lcl_start       = 1'b1;
            end
        end else if (ctl_q.state == S_DATA_RDY && tmr_expired) begin
            ctl_d.state = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rsp_retry = ctl_q.rsp_retry;
    assign rsp_done  = ctl_q.rsp_done;
    assign rsp_rdata = ctl_q.rsp_data;

    // R12: responses are exclusive
    p_excl_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_retry && rsp_done));

    // R12: every strobe is answered in the next cycle
    p_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_retry || rsp_done));

    // R12: no response without a strobe before it
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_retry || rsp_done) |-> $past(req_valid));

    // R2: a fresh read is retried and launched locally
    p_new_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_write && ctl_q.state == S_IDLE |=> rsp_retry && lcl_req);

    // R4: reads during an outstanding local read are retried
    p_wait_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_write && ctl_q.state == S_WAIT_LCL && !lcl_ack |=> rsp_retry);

    // R9: writes bounce while an entry is pending
    p_wr_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_is_write && cfg_wr_retry &&
        (ctl_q.state == S_WAIT_LCL || ctl_q.state == S_DATA_RDY) |=> rsp_retry);

    // R8: an expired entry with no request is dropped
    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.state == S_DATA_RDY && tmr_expired && !req_valid |=> ctl_q.state == S_IDLE);

endmodule

// File: tb/tb_pci_dly_rd_ctrl.sv
`timescale 1ns/1ps
module tb_pci_dly_rd_ctrl;
    localparam int TW  = 6;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_flush_new = 1'b0, cfg_wr_retry = 1'b0, cfg_wr_flush = 1'b0;
    logic        req_valid = 1'b0, req_is_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_retry, rsp_done;
    logic [31:0] rsp_rdata;
    logic        lcl_req;
    logic [31:0] lcl_addr;
    logic [3:0]  lcl_be;
    logic        lcl_ack = 1'b0;
    logic [31:0] lcl_rdata = '0;

    always #2 clk = ~clk;

    pci_dly_rd_ctrl #(.TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_flush_new(cfg_flush_new), .cfg_wr_retry(cfg_wr_retry), .cfg_wr_flush(cfg_wr_flush),
        .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr), .req_be(req_be),
        .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .lcl_req(lcl_req), .lcl_addr(lcl_addr), .lcl_be(lcl_be),
        .lcl_ack(lcl_ack), .lcl_rdata(lcl_rdata)
    );

    typedef struct {
        bit          retry;
        bit          is_read;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   lcl_xfers = 0;
    int   wcnt = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [31:0] a, input logic [3:0] be,
                          input bit exp_retry, input string tag);
        exp_t e;
        @(negedge clk);
        e.retry = exp_retry; e.is_read = !wr; e.data = mem_word(a); e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_is_write = wr; req_addr = a; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_is_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // local memory model
    initial begin
        forever begin
            @(negedge clk);
            if (lcl_ack) begin
                lcl_ack = 1'b0;
            end else if (rst_n && lcl_req) begin
                wcnt++;
                if (wcnt == LAT) begin
                    lcl_ack   = 1'b1;
                    lcl_rdata = mem_word(lcl_addr);
                    wcnt      = 0;
                    lcl_xfers++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    // response monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (rsp_retry || rsp_done)) begin
                n_cmp++;
                if (rsp_retry && rsp_done) begin
                    n_bad++;
                    $display("FAIL R12 both responses actual=11 expected=one-hot");
                end else if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R12 unexpected response actual=%0b%0b expected=none", rsp_retry, rsp_done);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rsp_retry !== e.retry) begin
                        n_bad++;
                        $display("FAIL %s retry actual=%0b expected=%0b", e.tag, rsp_retry, e.retry);
                    end else if (!e.retry && e.is_read && rsp_rdata !== e.data) begin
                        n_bad++;
                        $display("FAIL %s data actual=%h expected=%h", e.tag, rsp_rdata, e.data);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        check_eq("R12 all requests answered", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 lcl_req after reset", lcl_req, 0);
        check_eq("R1 responses after reset", {rsp_retry, rsp_done}, 0);

        // R2: new unaligned read, then R4 repeat while outstanding
        do_req(0, 32'h0000_1004, 4'b0110, 1, "R2 new read retried");
        check_eq("R2 lcl_req raised", lcl_req, 1);
        check_eq("R2 lcl_addr", lcl_addr, 32'h0000_1004);
        check_eq("R2 lcl_be", lcl_be, 4'b0110);
        do_req(0, 32'h0000_1004, 4'b0110, 1, "R4 match while local outstanding");
        idle(12);
        check_eq("R3 one local transfer", lcl_xfers, 1);

        // R6: mismatches retried, entry kept
        do_req(0, 32'h0000_1004, 4'b1111, 1, "R6 byte enables differ");
        do_req(0, 32'h0000_2000, 4'b0110, 1, "R6 address differs");
        idle(2);
        check_eq("R6 no extra local transfer", lcl_xfers, 1);
        do_req(0, 32'h0000_1004, 4'b0110, 0, "R5 matching read completes");
        do_req(0, 32'h0000_1004, 4'b0110, 1, "R5 repeat starts new delayed read");
        idle(12);
        check_eq("R5 second local transfer", lcl_xfers, 2);
        do_req(0, 32'h0000_1004, 4'b0110, 0, "R5 second completion");

        // R7: flush on new read
        cfg_flush_new = 1'b1;
        do_req(0, 32'h0000_3000, 4'b1111, 1, "R7 first read");
        idle(12);
        do_req(0, 32'h0000_4000, 4'b1111, 1, "R7 replacing read retried");
        idle(12);
        check_eq("R7 replacement launched", lcl_xfers, 4);
        check_eq("R7 replacement address", lcl_addr, 32'h0000_4000);
        do_req(0, 32'h0000_4000, 4'b1111, 0, "R7 replacement completes");
        do_req(0, 32'h0000_5000, 4'b0011, 1, "R7 new read");
        do_req(0, 32'h0000_6000, 4'b1111, 1, "R7 competing read during wait");
        idle(12);
        check_eq("R7 wait-state read not launched", lcl_xfers, 5);
        do_req(0, 32'h0000_5000, 4'b0011, 0, "R7 original still completes");
        cfg_flush_new = 1'b0;

        // R11: plain write keeps entry
        do_req(0, 32'h0000_7000, 4'b1111, 1, "R11 read");
        idle(12);
        do_req(1, 32'h0000_9990, 4'b1111, 0, "R11 write during pending done");
        do_req(0, 32'h0000_7000, 4'b1111, 0, "R11 entry kept after write");
        do_req(1, 32'h0000_9994, 4'b1111, 0, "R11 write with nothing pending");

        // R9: write retry wins over write flush
        cfg_wr_retry = 1'b1; cfg_wr_flush = 1'b1;
        do_req(0, 32'h0000_8000, 4'b1111, 1, "R9 read");
        idle(12);
        do_req(1, 32'h0000_9998, 4'b1111, 1, "R9 write retried");
        do_req(0, 32'h0000_8000, 4'b1111, 0, "R9 entry intact");
        cfg_wr_retry = 1'b0;

        // R10: write flush, data held and data outstanding
        do_req(0, 32'h0000_A000, 4'b1111, 1, "R10 read");
        idle(12);
        base = lcl_xfers;
        do_req(1, 32'h0000_999C, 4'b1111, 0, "R10 write proceeds");
        do_req(0, 32'h0000_A000, 4'b1111, 1, "R10 entry was discarded");
        idle(12);
        check_eq("R10 relaunch after flush", lcl_xfers, base + 1);
        do_req(0, 32'h0000_A000, 4'b1111, 0, "R10 relaunched read completes");
        do_req(0, 32'h0000_B000, 4'b1111, 1, "R10 read before outstanding flush");
        do_req(1, 32'h0000_99A0, 4'b1111, 0, "R10 write during outstanding");
        idle(12);
        do_req(0, 32'h0000_B000, 4'b1111, 1, "R10 returned word dropped");
        idle(12);
        do_req(0, 32'h0000_B000, 4'b1111, 0, "R10 new fetch completes");
        cfg_wr_flush = 1'b0;

        // R8: discard timer, 2^TW clocks
        do_req(0, 32'h0000_C000, 4'b1111, 1, "R8 read");
        idle(12);
        base = lcl_xfers;
        idle(40);
        do_req(0, 32'h0000_D000, 4'b1111, 1, "R8 before expiry retried");
        idle(2);
        check_eq("R8 no launch before expiry", lcl_xfers, base);
        idle(40);
        do_req(0, 32'h0000_D000, 4'b1111, 1, "R8 fresh read after expiry");
        idle(12);
        check_eq("R8 launch after expiry", lcl_xfers, base + 1);
        do_req(0, 32'h0000_D000, 4'b1111, 0, "R8 fresh read completes");
        idle(4);
        finish_run();
    end

endmodule